// File: doc/BRIEF.md
# Wake-up System Clock Selector

This block holds the register state that chooses the system clock. It keeps an active source code and an active divider code. A second pair of preset codes replaces the active pair when the system leaves sleep, provided a wake-switch mode bit is set. It also owns the enable levels of four oscillator sources. In order of source code these are the internal oscillator, the low-speed crystal, the high-speed oscillator and the external clock input.

The block has a single bus write port. Three addresses are decoded: the control word, the oscillator enable word and a protect register. The control and enable words change only after a fixed key has been written to the protect register. A select code that names a stopped source turns that source on. A wake-up reload stops every oscillator except the newly selected one and those flagged to keep running through sleep.

The block only drives select codes and enable levels. Clock muxing, division and the oscillators themselves are handled elsewhere.

Top module: `sysclk_wake_sel`

## Requirements
- R1: After synchronous reset, ctrl_word reads 0x0000, osc_word reads 0x0001, unlocked is 0, and sys_src and sys_div are both 0. Source 0 is the internal oscillator and divider 0 is 1/1.
- R2: The control word is written at address 0 and has this layout. Bit 15 is the wake-switch mode, bits 13:12 the wake divider, bits 9:8 the wake source, bits 5:4 the active divider and bits 1:0 the active source. Every other bit reads 0 (a read mask of 0xB333).
- R3: Writing 0x0096 to address 2 sets unlocked to 1, and writing any other value there clears it. While unlocked is 0, writes to address 0 or 1 change nothing.
- R4: Source codes are 0 = internal, 1 = low-speed crystal, 2 = high-speed, 3 = external. Divider codes 0..3 are 1/1, 1/2, 1/4 and 1/8. Sources 0 and 2 accept every divider, source 1 accepts only 0 and 1, and source 3 accepts only 0. A control write in which either the active pair or the wake pair is outside this set is dropped entirely.
- R5: The enable word is written at address 1. Bits 3:0 are the oscillator enables, with bit index equal to the source code. Bits 11:8 are the keep-running-in-sleep flags, in the same order. All other bits read 0.
- R6: The enable of the source named by sys_src is always 1. An accepted control write sets the enable of its new source, and an enable write cannot clear the enable of the active source.
- R7: When wake_evt pulses with the mode bit at 1, the wake source and wake divider are copied into sys_src and sys_div on that clock edge.
- R8: On that same reload, osc_en becomes the one-hot code of the wake source ORed with the old enables that have their keep flag set. The keep flags themselves are unchanged.
- R9: When wake_evt pulses with the mode bit at 0, ctrl_word and osc_word stay unchanged.
- R10: A bus write presented in the same cycle as a wake_evt pulse is discarded, whatever its address. This includes the protect register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 enable, 2 protect) |
| wr_data | input | 16 | Write data |
| wake_evt | input | 1 | Single-cycle wake-from-sleep pulse |
| sys_src | output | 2 | Active source code |
| sys_div | output | 2 | Active divider code |
| osc_en | output | 4 | Oscillator enables, bit index = source code |
| ctrl_word | output | 16 | Current control word |
| osc_word | output | 16 | Current enable word (enables and keep flags) |
| unlocked | output | 1 | Protect state, 1 = writes allowed |

## Verification
The assertions assume that wake_evt is a single-cycle pulse. They also assume that wr_addr 3 is never used, so the locked-write property can treat every non-protect address as a guarded register. The bench keeps to these limits. It draws addresses only from 0 to 2, and its wake pulses last one cycle and are separated by at least one quiet cycle. Random control data deliberately mixes legal and reserved source and divider pairs. The key is written half the time, so the locked and unlocked paths, rejected writes and wake collisions are all reached.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int WORD_W  = 16;
    localparam int SRC_W   = 2;
    localparam int DIV_W   = 2;
    localparam int NUM_SRC = 1 << SRC_W;

    // field positions inside the control word
    localparam int MODE_BIT = 15;
    localparam int WDIV_LO  = 12;
    localparam int WSRC_LO  = 8;
    localparam int ADIV_LO  = 4;
    localparam int ASRC_LO  = 0;

    // field positions inside the enable word
    localparam int EN_LO   = 0;
    localparam int KEEP_LO = 8;

    typedef enum logic [SRC_W-1:0] {
        SRC_INT = 2'd0,
        SRC_LSX = 2'd1,
        SRC_HSO = 2'd2,
        SRC_EXT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_OSC  = 2'd1,
        ADDR_LOCK = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    typedef struct packed {
        logic             mode;
        logic [DIV_W-1:0] wdiv;
        src_e             wsrc;
        logic [DIV_W-1:0] adiv;
        src_e             asrc;
    } ctrl_t;

    function automatic logic pair_legal(input src_e s, input logic [DIV_W-1:0] d);
        case (s)
            SRC_INT, SRC_HSO: pair_legal = 1'b1;
            SRC_LSX:          pair_legal = (d < 2'd2);
            default:          pair_legal = (d == 2'd0);
        endcase
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.mode = w[MODE_BIT];
        c.wdiv = w[WDIV_LO +: DIV_W];
        c.wsrc = src_e'(w[WSRC_LO +: SRC_W]);
        c.adiv = w[ADIV_LO +: DIV_W];
        c.asrc = src_e'(w[ASRC_LO +: SRC_W]);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_BIT]           = c.mode;
        w[WDIV_LO +: DIV_W]   = c.wdiv;
        w[WSRC_LO +: SRC_W]   = c.wsrc;
        w[ADIV_LO +: DIV_W]   = c.adiv;
        w[ASRC_LO +: SRC_W]   = c.asrc;
        return w;
    endfunction

endpackage

// File: rtl/sclk_lock.sv
module sclk_lock
    import sclk_pkg::*;
#(
    parameter logic [WORD_W-1:0] KEY = 16'h0096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_wr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              unlocked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (lock_wr) begin
            unlocked <= (wr_data == KEY);
        end
    end

endmodule

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              unlocked,
    input  logic              wake_evt,
    output ctrl_t             ctrl_q,
    output logic              reload,
    output src_e              sel_next
);

    ctrl_t cand;
    logic  accept;

    always_comb begin
        cand   = unpack_ctrl(wr_data);
        reload = wake_evt && ctrl_q.mode;
        accept = ctrl_wr && unlocked
                 && pair_legal(cand.asrc, cand.adiv)
                 && pair_legal(cand.wsrc, cand.wdiv);
        if (reload) begin
            sel_next = ctrl_q.wsrc;
        end else if (accept) begin
            sel_next = cand.asrc;
        end else begin
            sel_next = ctrl_q.asrc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: 1'b0, wdiv: '0, wsrc: SRC_INT, adiv: '0, asrc: SRC_INT};
        end else if (reload) begin
            ctrl_q.asrc <= ctrl_q.wsrc;
            ctrl_q.adiv <= ctrl_q.wdiv;
        end else if (accept) begin
            ctrl_q <= cand;
        end
    end

endmodule

// File: rtl/sclk_osc_en.sv
module sclk_osc_en
    import sclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               osc_wr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               unlocked,
    input  logic               reload,
    input  src_e               sel_next,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] keep_q
);

    logic wr_ok;
    assign wr_ok = osc_wr && unlocked;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic nxt;
        always_comb begin
            if (reload) begin
                nxt = en_q[i] && keep_q[i];
            end else if (wr_ok) begin
                nxt = wr_data[EN_LO + i];
            end else begin
                nxt = en_q[i];
            end
            if (sel_next == src_e'(i)) begin
                nxt = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i]   <= (i == int'(SRC_INT));
                keep_q[i] <= 1'b0;
            end else begin
                en_q[i] <= nxt;
                if (wr_ok) begin
                    keep_q[i] <= wr_data[KEEP_LO + i];
                end
            end
        end
    end

endmodule

// File: rtl/sysclk_wake_sel.sv
module sysclk_wake_sel
    import sclk_pkg::*;
#(
    parameter logic [15:0] UNLOCK_KEY = 16'h0096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic        wake_evt,
    output logic [1:0]  sys_src,
    output logic [1:0]  sys_div,
    output logic [3:0]  osc_en,
    output logic [15:0] ctrl_word,
    output logic [15:0] osc_word,
    output logic        unlocked
);

    logic               bus_ok;
    logic               ctrl_wr;
    logic               osc_wr;
    logic               lock_wr;
    ctrl_t              ctrl_q;
    logic               reload;
    src_e               sel_next;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] keep_q;

    // a wake pulse takes the cycle; any bus write beside it is dropped
    assign bus_ok  = wr_en && !wake_evt;
    assign ctrl_wr = bus_ok && (addr_e'(wr_addr) == ADDR_CTRL);
    assign osc_wr  = bus_ok && (addr_e'(wr_addr) == ADDR_OSC);
    assign lock_wr = bus_ok && (addr_e'(wr_addr) == ADDR_LOCK);

    sclk_lock #(.KEY(UNLOCK_KEY)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .lock_wr  (lock_wr),
        .wr_data  (wr_data),
        .unlocked (unlocked)
    );

    sclk_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wr_data  (wr_data),
        .unlocked (unlocked),
        .wake_evt (wake_evt),
        .ctrl_q   (ctrl_q),
        .reload   (reload),
        .sel_next (sel_next)
    );

    sclk_osc_en u_osc (
        .clk      (clk),
        .rst      (rst),
        .osc_wr   (osc_wr),
        .wr_data  (wr_data),
        .unlocked (unlocked),
        .reload   (reload),
        .sel_next (sel_next),
        .en_q     (en_q),
        .keep_q   (keep_q)
    );

    always_comb begin
        sys_src   = ctrl_q.asrc;
        sys_div   = ctrl_q.adiv;
        osc_en    = en_q;
        ctrl_word = pack_ctrl(ctrl_q);
        osc_word  = '0;
        osc_word[EN_LO +: NUM_SRC]   = en_q;
        osc_word[KEEP_LO +: NUM_SRC] = keep_q;
    end

endmodule

// File: rtl/sysclk_wake_sel_chk.sv
module sysclk_wake_sel_chk
    import sclk_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic        wake_evt,
    input logic [1:0]  sys_src,
    input logic [1:0]  sys_div,
    input logic [3:0]  osc_en,
    input logic [15:0] ctrl_word,
    input logic [15:0] osc_word,
    input logic        unlocked
);

    // R6
    active_en_chk: assert property (@(posedge clk) disable iff (rst)
        osc_en[sys_src] == 1'b1);

    // R4
    legal_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pair_legal(src_e'(sys_src), sys_div)
        && pair_legal(src_e'(ctrl_word[9:8]), ctrl_word[13:12]));

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wake_evt && !unlocked && wr_addr != 2'd2)
        |=> ($stable(ctrl_word) && $stable(osc_word)));

    // R7
    wake_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_evt && ctrl_word[15])
        |=> (sys_src == $past(ctrl_word[9:8]) && sys_div == $past(ctrl_word[13:12])));

    // R8
    wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_evt && ctrl_word[15])
        |=> (osc_en == ($past(osc_en & osc_word[11:8]) | (4'b0001 << $past(ctrl_word[9:8])))
             && $stable(osc_word[11:8])));

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_evt && !ctrl_word[15])
        |=> ($stable(ctrl_word) && $stable(osc_word)));

    // R10
    wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> $stable(unlocked));

endmodule

bind sysclk_wake_sel sysclk_wake_sel_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wake_evt  (wake_evt),
    .sys_src   (sys_src),
    .sys_div   (sys_div),
    .osc_en    (osc_en),
    .ctrl_word (ctrl_word),
    .osc_word  (osc_word),
    .unlocked  (unlocked)
);

// File: tb/sysclk_wake_sel_tb.sv
module sysclk_wake_sel_tb;

    localparam logic [15:0] KEY  = 16'h0096;
    localparam logic [15:0] MASK = 16'hB333;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        wake_evt = 1'b0;
    logic [1:0]  sys_src;
    logic [1:0]  sys_div;
    logic [3:0]  osc_en;
    logic [15:0] ctrl_word;
    logic [15:0] osc_word;
    logic        unlocked;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model of the register state
    logic [15:0] m_ctrl;
    logic [3:0]  m_en;
    logic [3:0]  m_keep;
    logic        m_unl;

    always #5 clk = ~clk;

    sysclk_wake_sel u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wake_evt  (wake_evt),
        .sys_src   (sys_src),
        .sys_div   (sys_div),
        .osc_en    (osc_en),
        .ctrl_word (ctrl_word),
        .osc_word  (osc_word),
        .unlocked  (unlocked)
    );

    function automatic bit legal(input logic [1:0] s, input logic [1:0] d);
        case (s)
            2'd0, 2'd2: return 1'b1;
            2'd1:       return d < 2'd2;
            default:    return d == 2'd0;
        endcase
    endfunction

    function automatic logic [3:0] onehot(input logic [1:0] s);
        return 4'b0001 << s;
    endfunction

    task automatic model_step(input logic we, input logic [1:0] a,
                              input logic [15:0] d, input logic wk);
        if (wk) begin
            if (m_ctrl[15]) begin
                m_en = onehot(m_ctrl[9:8]) | (m_en & m_keep);
                m_ctrl[1:0] = m_ctrl[9:8];
                m_ctrl[5:4] = m_ctrl[13:12];
            end
        end else if (we) begin
            case (a)
                2'd2: m_unl = (d == KEY);
                2'd0: if (m_unl && legal(d[1:0], d[5:4]) && legal(d[9:8], d[13:12])) begin
                          m_ctrl = d & MASK;
                          m_en   = m_en | onehot(d[1:0]);
                      end
                2'd1: if (m_unl) begin
                          m_en   = d[3:0] | onehot(m_ctrl[1:0]);
                          m_keep = d[11:8];
                      end
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input logic we, input logic [1:0] a,
                       input logic [15:0] d, input logic wk);
        wr_en = we; wr_addr = a; wr_data = d; wake_evt = wk;
        @(posedge clk);
        model_step(we, a, d, wk);
        @(negedge clk);
        wr_en = 1'b0; wake_evt = 1'b0;
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check16({tag, " ctrl_word"}, ctrl_word, m_ctrl);
        check16({tag, " osc_word"}, osc_word, {4'h0, m_keep, 4'h0, m_en});
        check16({tag, " unlocked"}, {15'h0, unlocked}, {15'h0, m_unl});
        check16({tag, " src/div"}, {12'h0, sys_src, sys_div}, {12'h0, m_ctrl[1:0], m_ctrl[5:4]});
        check16({tag, " osc_en"}, {12'h0, osc_en}, {12'h0, m_en});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctrl = 16'h0; m_en = 4'b0001; m_keep = 4'h0; m_unl = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check16("R1 ctrl_word", ctrl_word, 16'h0000);
        check16("R1 osc_word", osc_word, 16'h0001);
        check16("R1 unlocked", {15'h0, unlocked}, 16'h0);

        // R3 locked control write has no effect
        cyc(1, 2'd0, 16'h0002, 0);
        check16("R3 locked ctrl", ctrl_word, 16'h0000);
        cyc(1, 2'd2, KEY, 0);
        check16("R3 unlock", {15'h0, unlocked}, 16'h1);

        // R4 reserved wake pair drops the write
        cyc(1, 2'd0, 16'hFFFF, 0);
        check16("R4 reserved pair", ctrl_word, 16'h0000);
        // R4 reserved active pair (low-speed at 1/4)
        cyc(1, 2'd0, 16'h0021, 0);
        check16("R4 lsx quarter", ctrl_word, 16'h0000);

        // R2 layout and read mask, R6 auto-start of high-speed
        cyc(1, 2'd0, 16'hF2E6, 0);
        check16("R2 mask", ctrl_word, 16'hB222);
        check16("R6 auto start", {12'h0, osc_en}, 16'h0005);

        // R6 enable write cannot stop the active source
        cyc(1, 2'd1, 16'h0000, 0);
        check16("R6 keep active", {12'h0, osc_en}, 16'h0004);
        // R5 enable and keep layout, reserved bits read 0
        cyc(1, 2'd1, 16'hF2FF, 0);
        check16("R5 layout", osc_word, 16'h020F);

        // set wake preset external 1/1, active high-speed 1/1, mode on
        cyc(1, 2'd0, 16'h8302, 0);
        check16("R2 preset", ctrl_word, 16'h8302);

        // R7 R8 R10 wake with a colliding bad protect write
        cyc(1, 2'd2, 16'h0000, 1);
        check16("R7 reload src/div", {12'h0, sys_src, sys_div}, 16'h000C);
        check16("R8 gate enables", osc_word, 16'h020A);
        check16("R10 collided write", {15'h0, unlocked}, 16'h1);

        // R9 mode off: wake changes nothing
        cyc(1, 2'd0, 16'h0301, 0);
        check16("R9 setup", ctrl_word, 16'h0301);
        cyc(0, 2'd0, 16'h0, 1);
        check16("R9 ctrl held", ctrl_word, 16'h0301);
        check16("R9 osc held", osc_word, 16'h020A);

        // R3 relock with wrong value, then enable write ignored
        cyc(1, 2'd2, 16'h0097, 0);
        cyc(1, 2'd1, 16'h0F0F, 0);
        check16("R3 relocked", {15'h0, unlocked}, 16'h0);
        check16("R3 locked osc", osc_word, 16'h020A);

        check_all("R1 model sync");

        // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 1500; i++) begin
            logic        we;
            logic        wk;
            logic [1:0]  a;
            logic [15:0] d;
            wk = ($urandom % 8) == 0;
            we = ($urandom % 4) != 0;
            a  = 2'($urandom % 3);
            d  = 16'($urandom);
            if (a == 2'd2 && ($urandom % 2) == 0) d = KEY;
            if (a == 2'd0 && ($urandom % 3) == 0) d[15] = 1'b1;
            cyc(we, a, d, wk);
            check_all("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
            if (wk) cyc(0, 2'd0, 16'h0, 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule